// File: doc/BRIEF.md
# Fabric Error Detect and Capture Unit

This block is the error-reporting register file that sits next to an interconnect fabric. The fabric signals four kinds of error as single-cycle pulses: a local access window miss, a coherency violation, an unavailable target, and a multicast stash. Each pulse comes with the 40-bit address of the failing transaction, the 8-bit ID of its source and a 5-bit capture type. The block records each error kind in a sticky status bit. Recording can be suppressed per kind. A level interrupt is raised for any recorded kind whose interrupt enable is set.

The first recorded error also freezes its attributes in a set of capture registers and sets a capture-valid flag. Errors that arrive while the flag is set still mark their status bits, but they do not touch the captured attributes. Software services the block through a 32-bit register port. It reads the status word and writes the same value back. The write clears exactly the status bits that were set. If the capture-valid flag was among them, it clears that too and re-arms capture.

Top module: `fabric_err_unit`

## Requirements
- R1: After a synchronous reset, every register reads zero and `irq` is low.
- R2: Register offsets and status bits:
  - A pulse on `evt_pulse[k]` sets status bit k of offset 0x00 on the next clock edge.
  - Bit 0 is local access, bit 1 is coherency, bit 2 is unavailable target and bit 3 is multicast stash.
  - If bit k of the detection-disable register (offset 0x04, same bit positions) is 1, the pulse leaves status untouched.
- R3: Interrupt behaviour:
  - `irq` is high exactly when some status bit in 3:0 is set and bit k of the interrupt-enable register (offset 0x08, same positions) is also set.
  - `irq` stays high until those status bits are cleared or their enables are removed.
- R4: Clearing status:
  - Writing offset 0x00 clears each status bit 3:0 whose write-data bit is 1.
  - Status bits written with 0 keep their value.
- R5: First capture:
  - When a recorded error occurs with capture-valid clear, capture-valid (status bit 31) becomes 1.
  - The event's capture type appears in status bits 30:26.
  - Its source ID appears in bits 25:18 of offset 0x0C.
  - Its address appears split: bits 39:32 in bits 7:0 of offset 0x10, and bits 31:0 in offset 0x14.
  - The recorded kinds of that cycle appear in bits 3:0 of offset 0x18.
- R6: While capture-valid is set, later errors set their status bits but leave the capture type and offsets 0x0C to 0x18 unchanged.
- R7: Re-arming capture:
  - Writing offset 0x00 with bit 31 set clears capture-valid and the capture type.
  - If a recorded error arrives in that same cycle, it is captured instead and capture-valid stays 1.
- R8: An error pulse in the same cycle as a write clearing its status bit leaves the bit set.
- R9: Undefined and read-only locations:
  - Writes to undefined offsets, to undefined bits, or to offsets 0x0C to 0x18 have no effect.
  - Undefined offsets and bits read as zero.
- R10: An error whose kind is disabled never sets capture-valid and never loads the capture registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 4 | One-cycle error pulses, one per kind |
| evt_addr | input | 40 | Address of the failing transaction |
| evt_src | input | 8 | Source ID of the failing transaction |
| evt_ctype | input | 5 | Capture type of the failing transaction |
| reg_addr | input | 5 | Byte offset of the register access |
| reg_wr_en | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
Any wrong internal state in this block reaches the ports within one clock. A lost or spurious status bit shows at the status offset and on `irq` at the first read after the edge that recorded the event. A capture that loaded when it should have stayed frozen shows as a changed source, address or type word at the next read. The bench therefore reads every register right after each event and after each write-back. It drives deliberate overlaps, a clear in the same cycle as a new error, so that priority faults appear as a single wrong bit.

// File: rtl/fec_pkg.sv
package fec_pkg;
    parameter int ERR_N  = 4;
    parameter int ADDR_W = 40;
    parameter int SRC_W  = 8;
    parameter int CT_W   = 5;
    parameter int RA_W   = 5;
    parameter int DATA_W = 32;

    localparam int ADDR_HI_W = ADDR_W - 32;
    localparam int SRC_LSB   = 18;
    localparam int CT_LSB    = 26;
    localparam int CAPV_BIT  = 31;

    localparam logic [RA_W-1:0] OFF_STAT  = 5'h00;
    localparam logic [RA_W-1:0] OFF_DIS   = 5'h04;
    localparam logic [RA_W-1:0] OFF_IEN   = 5'h08;
    localparam logic [RA_W-1:0] OFF_ATTR  = 5'h0C;
    localparam logic [RA_W-1:0] OFF_AHI   = 5'h10;
    localparam logic [RA_W-1:0] OFF_ALO   = 5'h14;
    localparam logic [RA_W-1:0] OFF_ATTR2 = 5'h18;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [SRC_W-1:0]  src;
        logic [CT_W-1:0]   ctype;
        logic [ERR_N-1:0]  kinds;
    } cap_t;

    function automatic logic [ERR_N-1:0] kind_field(input logic [DATA_W-1:0] d);
        return d[ERR_N-1:0];
    endfunction
endpackage

// File: rtl/fec_masks.sv
module fec_masks
    import fec_pkg::*;
#(
    parameter int N = ERR_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_dis,
    input  logic         wr_ien,
    input  logic [N-1:0] wbits,
    output logic [N-1:0] dis_q,
    output logic [N-1:0] ien_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dis_q <= '0;
            ien_q <= '0;
        end else begin
            if (wr_dis) dis_q <= wbits;
            if (wr_ien) ien_q <= wbits;
        end
    end
endmodule

// File: rtl/fec_status.sv
module fec_status
    import fec_pkg::*;
#(
    parameter int N = ERR_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] det,
    input  logic [N-1:0] clr,
    output logic [N-1:0] st_q
);
    // per-bit sticky flag; a detection in the clearing cycle takes priority
    for (genvar k = 0; k < N; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)         st_q[k] <= 1'b0;
            else if (det[k]) st_q[k] <= 1'b1;
            else if (clr[k]) st_q[k] <= 1'b0;
        end
    end
endmodule

// File: rtl/fec_capture.sv
module fec_capture
    import fec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ERR_N-1:0]  det,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SRC_W-1:0]  src,
    input  logic [CT_W-1:0]   ctype,
    input  logic              clr_cap,
    output cap_t              cap_q,
    output logic              cap_vld
);
    logic load;
    assign load = (|det) && (!cap_vld || clr_cap);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q   <= '0;
            cap_vld <= 1'b0;
        end else if (load) begin
            cap_q   <= '{addr: addr, src: src, ctype: ctype, kinds: det};
            cap_vld <= 1'b1;
        end else if (clr_cap) begin
            cap_q.ctype <= '0;
            cap_vld     <= 1'b0;
        end
    end
endmodule

// File: rtl/fabric_err_unit.sv
module fabric_err_unit
    import fec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ERR_N-1:0]  evt_pulse,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic [SRC_W-1:0]  evt_src,
    input  logic [CT_W-1:0]   evt_ctype,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic [ERR_N-1:0] dis_q, ien_q, st_q, det, st_clr;
    logic             wr_stat, clr_cap, cap_vld;
    cap_t             cap_q;

    assign wr_stat = reg_wr_en && (reg_addr == OFF_STAT);
    assign st_clr  = wr_stat ? kind_field(reg_wdata) : '0;
    assign clr_cap = wr_stat && reg_wdata[CAPV_BIT];
    assign det     = evt_pulse & ~dis_q;

    fec_masks u_masks (
        .clk    (clk),
        .rst    (rst),
        .wr_dis (reg_wr_en && (reg_addr == OFF_DIS)),
        .wr_ien (reg_wr_en && (reg_addr == OFF_IEN)),
        .wbits  (kind_field(reg_wdata)),
        .dis_q  (dis_q),
        .ien_q  (ien_q)
    );

    fec_status u_status (
        .clk  (clk),
        .rst  (rst),
        .det  (det),
        .clr  (st_clr),
        .st_q (st_q)
    );

    fec_capture u_capture (
        .clk     (clk),
        .rst     (rst),
        .det     (det),
        .addr    (evt_addr),
        .src     (evt_src),
        .ctype   (evt_ctype),
        .clr_cap (clr_cap),
        .cap_q   (cap_q),
        .cap_vld (cap_vld)
    );

    assign irq = |(st_q & ien_q);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_STAT: begin
                reg_rdata[ERR_N-1:0]       = st_q;
                reg_rdata[CT_LSB +: CT_W]  = cap_q.ctype;
                reg_rdata[CAPV_BIT]        = cap_vld;
            end
            OFF_DIS:   reg_rdata[ERR_N-1:0]          = dis_q;
            OFF_IEN:   reg_rdata[ERR_N-1:0]          = ien_q;
            OFF_ATTR:  reg_rdata[SRC_LSB +: SRC_W]   = cap_q.src;
            OFF_AHI:   reg_rdata[ADDR_HI_W-1:0]      = cap_q.addr[ADDR_W-1:32];
            OFF_ALO:   reg_rdata                     = cap_q.addr[31:0];
            OFF_ATTR2: reg_rdata[ERR_N-1:0]          = cap_q.kinds;
            default:   reg_rdata                     = '0;
        endcase
    end
endmodule

// File: rtl/fabric_err_unit_chk.sv
module fabric_err_unit_chk
    import fec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [RA_W-1:0]   wr_addr,
    input logic [ERR_N-1:0]  evt,
    input logic [ERR_N-1:0]  dis,
    input logic [ERR_N-1:0]  st,
    input logic              cap_vld,
    input logic [ADDR_W-1:0] cap_addr,
    input logic [SRC_W-1:0]  cap_src,
    input logic              irq
);
    logic stat_wr, ctl_wr;
    assign stat_wr = wr_en && (wr_addr == OFF_STAT);
    assign ctl_wr  = wr_en && ((wr_addr == OFF_STAT) || (wr_addr == OFF_IEN));

    // R2
    no_spurious_status_chk: assert property (@(posedge clk) disable iff (rst)
        ((st & ~$past(st) & ~$past(evt & ~dis)) == '0));

    // R8
    event_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ((evt & ~dis) != '0) |=> ((st & $past(evt & ~dis)) == $past(evt & ~dis)));

    // R3
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !ctl_wr) |=> irq);

    // R5
    capture_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (!cap_vld && ((evt & ~dis) != '0)) |=> cap_vld);

    // R6
    capture_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_vld && !stat_wr) |=> ($stable(cap_addr) && $stable(cap_src) && cap_vld));
endmodule

bind fabric_err_unit fabric_err_unit_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr_en),
    .wr_addr  (reg_addr),
    .evt      (evt_pulse),
    .dis      (dis_q),
    .st       (st_q),
    .cap_vld  (cap_vld),
    .cap_addr (cap_q.addr),
    .cap_src  (cap_q.src),
    .irq      (irq)
);

// File: tb/fabric_err_unit_tb.sv
module fabric_err_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  evt_pulse = '0;
    logic [39:0] evt_addr = '0;
    logic [7:0]  evt_src = '0;
    logic [4:0]  evt_ctype = '0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fabric_err_unit u_dut (
        .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .evt_addr(evt_addr),
        .evt_src(evt_src), .evt_ctype(evt_ctype), .reg_addr(reg_addr),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    // {disable, irq enable, event, expected status[3:0], expected irq}
    localparam logic [16:0] VEC [8] = '{
        {4'h0, 4'hF, 4'h1, 4'h1, 1'b1},
        {4'h0, 4'h0, 4'h3, 4'h3, 1'b0},
        {4'h2, 4'hF, 4'h3, 4'h1, 1'b1},
        {4'hF, 4'hF, 4'hF, 4'h0, 1'b0},
        {4'h0, 4'h8, 4'h4, 4'h4, 1'b0},
        {4'h0, 4'h8, 4'hC, 4'hC, 1'b1},
        {4'h5, 4'h5, 4'hF, 4'hA, 1'b0},
        {4'h0, 4'h2, 4'hA, 4'hA, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [3:0] k, input logic [39:0] a,
                         input logic [7:0] s, input logic [4:0] t);
        @(negedge clk);
        evt_pulse = k; evt_addr = a; evt_src = s; evt_ctype = t;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(5'(a * 4), v);
            chk("R1 reset reg", v, 32'h0);
        end
        chk("R1 reset irq", {31'h0, irq}, 32'h0);

        // table walk: R2 R3 R4 R10
        for (int i = 0; i < 8; i++) begin
            wr(5'h04, {28'h0, VEC[i][16:13]});
            wr(5'h08, {28'h0, VEC[i][12:9]});
            pulse(VEC[i][8:5], 40'h1, 8'h1, 5'h1);
            rd(5'h00, v);
            chk("R2 status kinds", {28'h0, v[3:0]}, {28'h0, VEC[i][4:1]});
            chk("R3 irq level", {31'h0, irq}, {31'h0, VEC[i][0]});
            chk("R10 capture valid only when recorded", {31'h0, v[31]},
                {31'h0, (VEC[i][4:1] != 4'h0)});
            wr(5'h00, v);
            rd(5'h00, v);
            chk("R4 write-back clears", v, 32'h0);
            chk("R3 irq drops after clear", {31'h0, irq}, 32'h0);
        end
        wr(5'h04, 32'h0);
        wr(5'h08, 32'hF);

        // R5 first capture
        pulse(4'h1, 40'hA5_1234_5678, 8'h3C, 5'h11);
        rd(5'h00, v); chk("R5 status with capture type", v, 32'hC400_0001);
        // R6 second error keeps first capture
        pulse(4'h2, 40'h07_DEAD_BEEF, 8'h81, 5'h02);
        rd(5'h00, v); chk("R6 status bits merge, type frozen", v, 32'hC400_0003);
        rd(5'h0C, v); chk("R6 source frozen", v, 32'h00F0_0000);
        rd(5'h10, v); chk("R5 address high", v, 32'h0000_00A5);
        rd(5'h14, v); chk("R5 address low", v, 32'h1234_5678);
        rd(5'h18, v); chk("R5 recorded kinds", v, 32'h0000_0001);

        // R7 clear re-arms capture
        wr(5'h00, 32'hC400_0003);
        rd(5'h00, v); chk("R7 cleared", v, 32'h0);
        pulse(4'h2, 40'h07_DEAD_BEEF, 8'h81, 5'h02);
        rd(5'h00, v); chk("R7 fresh capture status", v, 32'h8800_0002);
        rd(5'h0C, v); chk("R7 fresh source", v, 32'h0204_0000);
        rd(5'h10, v); chk("R7 fresh address high", v, 32'h0000_0007);
        rd(5'h14, v); chk("R7 fresh address low", v, 32'hDEAD_BEEF);

        // R4 partial clear leaves other bits
        pulse(4'h1, 40'h0, 8'h0, 5'h0);
        wr(5'h00, 32'h0000_0001);
        rd(5'h00, v); chk("R4 partial clear", v, 32'h8800_0002);
        chk("R3 irq held by remaining bit", {31'h0, irq}, 32'h1);

        // R7 clear of capture-valid coinciding with a new error
        @(negedge clk);
        reg_addr = 5'h00; reg_wdata = 32'h8800_0002; reg_wr_en = 1'b1;
        evt_pulse = 4'h4; evt_addr = 40'h00_0000_0100; evt_src = 8'h05; evt_ctype = 5'h1F;
        @(negedge clk);
        reg_wr_en = 1'b0; evt_pulse = '0;
        rd(5'h00, v); chk("R7 same-cycle recapture", v, 32'hFC00_0004);
        rd(5'h14, v); chk("R7 same-cycle address", v, 32'h0000_0100);
        rd(5'h0C, v); chk("R7 same-cycle source", v, 32'h0014_0000);

        // R8 event wins over clear of the same bit
        @(negedge clk);
        reg_addr = 5'h00; reg_wdata = 32'h0000_0002; reg_wr_en = 1'b1;
        evt_pulse = 4'h2;
        @(negedge clk);
        reg_wr_en = 1'b0; evt_pulse = '0;
        rd(5'h00, v); chk("R8 event beats clear", v, 32'hFC00_0006);
        rd(5'h14, v); chk("R6 no overwrite by later error", v, 32'h0000_0100);
        wr(5'h00, 32'hFC00_0006);
        rd(5'h00, v); chk("R4 all cleared", v, 32'h0);

        // R10 disabled error does not capture
        wr(5'h04, 32'hF);
        pulse(4'hF, 40'hFF_FFFF_FFFF, 8'hFF, 5'h1F);
        rd(5'h00, v); chk("R10 disabled no status or capture", v, 32'h0);
        rd(5'h14, v); chk("R10 capture untouched", v, 32'h0000_0100);

        // R9 undefined and read-only locations
        wr(5'h04, 32'hFFFF_FFF0);
        rd(5'h04, v); chk("R9 undefined mask bits", v, 32'h0);
        wr(5'h1C, 32'hFFFF_FFFF);
        rd(5'h1C, v); chk("R9 undefined offset", v, 32'h0);
        wr(5'h14, 32'hFFFF_FFFF);
        rd(5'h14, v); chk("R9 address read-only", v, 32'h0000_0100);
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h18, v); chk("R9 attribute 2 read-only", v, 32'h0000_0004);
        wr(5'h0C, 32'hFFFF_FFFF);
        rd(5'h0C, v); chk("R9 attribute read-only", v, 32'h0014_0000);
        rd(5'h01, v); chk("R9 unaligned offset", v, 32'h0);

        // R1 reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(5'h14, v); chk("R1 capture cleared by reset", v, 32'h0);
        rd(5'h08, v); chk("R1 enable cleared by reset", v, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule